// File: doc/BRIEF.md
# CAN Error Status and Interrupt Register

This block is one 32-bit status word of a CAN protocol controller. It gathers one-cycle error pulses from the bit-level engine and holds each one as a sticky flag. A read of the word returns those flags and clears them in the same access. The same word also shows live controller state. This state covers two error-counter warning levels, an idle indication, a transfer-direction indication and a two-bit fault-confinement code.

Five interrupt flags are kept in the word: transmit warning, receive warning, bus-off, error and wake-up. Software clears each flag by writing a 1 to its bit. A warning flag is set only when the warning enable is high and its counter rises to the warning level. Each interrupt request output is the registered AND of a flag and its mask bit.

Access uses a select, a read strobe, a write strobe and a 32-bit data path. Read data is registered and appears the cycle after the read strobe.

Top module: `can_esr`

## Requirements
- R1: After a synchronous reset, every interrupt flag, error flag and interrupt request is 0, and a read returns 0x00000000 when all status inputs are low.
- R2: An `err_evt` pulse sets its error flag. The flag stays set until the next selected read. That read returns the flag in bits [15:10] (bus_rdata[15] = err_evt[5] ... bus_rdata[10] = err_evt[0]) and then clears all six flags.
- R3: If an error pulse arrives in the same cycle as a clearing read, that read does not show it, but the flag stays set for the following read.
- R4: Live status reads as follows: bit 9 is tx_err_cnt >= 96, bit 8 is rx_err_cnt >= 96, bit 7 is st_idle, bit 6 is st_txrx, and bits [5:4] are st_fault. Writes never change these bits.
- R5: The interrupt flags sit at bit 17 (tx warning), bit 16 (rx warning), bit 2 (bus-off), bit 1 (error) and bit 0 (wake-up). A write with a 1 in a flag's bit clears that flag. A write with 0 leaves it unchanged. Writes have no effect on the error flags.
- R6: The tx warning flag sets only on a cycle where warn_en is 1, tx_err_cnt >= 96 holds, and the same condition did not hold in the previous cycle. The flag does not set while the counter stays high, or while warn_en is 0.
- R7: The rx warning flag follows the rule in R6, using rx_err_cnt and the same warn_en.
- R8: A pulse on boff_evt, errint_evt or wake_evt sets the bus-off, error or wake-up flag.
- R9: When a flag's set condition and a write-1 clear of that flag occur in the same cycle, the flag ends set.
- R10: irq = {tx warn, rx warn, bus-off, error, wake-up} flags AND irq_mask, taken from the flags of the previous cycle (one register stage).
- R11: Bits [31:18] and bit 3 always read 0.
- R12: Strobes with bus_sel low do not read, clear or write anything, and bus_rdata keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register selected |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (1 clears an interrupt flag) |
| bus_rdata | output | 32 | Registered read data |
| err_evt | input | 6 | Error pulses: bit1, bit0, ack, crc, form, stuff (MSB first) |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| st_idle | input | 1 | Bus idle status |
| st_txrx | input | 1 | Transmitting/receiving status |
| st_fault | input | 2 | Fault-confinement state |
| boff_evt | input | 1 | Bus-off entry pulse |
| errint_evt | input | 1 | Error interrupt pulse |
| wake_evt | input | 1 | Wake-up pulse |
| warn_en | input | 1 | Enables the warning interrupt flags |
| irq_mask | input | 5 | Masks {txw, rxw, boff, err, wake} |
| irq | output | 5 | Interrupt requests, same order as irq_mask |

## Verification
A table of counter pairs drives the warning function. It moves each counter below the threshold, exactly onto it, above it while already high, and back to zero, with the enable on and off. These patterns separate a rising-edge detector from a level detector, show an off-by-one threshold, and show whether the enable gates the flag. Directed cases then place an error pulse on the same cycle as a read and a set on the same cycle as a write-1 clear. Further cases check writes of 0 against writes of 1, unselected strobes, and partial masks. Together they tell sticky flags apart from live bits and show the one-cycle delay of the request lines.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
  localparam int ESR_W    = 32;
  localparam int N_ERR    = 6;
  localparam int N_INT    = 5;
  localparam int N_WARN   = 2;

  localparam int POS_TWI  = 17;
  localparam int POS_RWI  = 16;
  localparam int POS_ERRH = 15;
  localparam int POS_ERRL = POS_ERRH - N_ERR + 1;
  localparam int POS_TXW  = 9;
  localparam int POS_RXW  = 8;
  localparam int POS_IDLE = 7;
  localparam int POS_TXRX = 6;
  localparam int POS_FLTH = 5;
  localparam int POS_FLTL = 4;
  localparam int POS_BOFF = 2;
  localparam int POS_EINT = 1;
  localparam int POS_WAKE = 0;

  typedef enum int {
    IX_WAKE = 0,
    IX_EINT = 1,
    IX_BOFF = 2,
    IX_RWRN = 3,
    IX_TWRN = 4
  } irq_ix_e;

  typedef struct packed {
    logic       txw;
    logic       rxw;
    logic       idle;
    logic       txrx;
    logic [1:0] fault;
  } live_stat_t;

  function automatic logic [ESR_W-1:0] pack_word(
    input logic [N_ERR-1:0] errs,
    input live_stat_t       st,
    input logic [N_INT-1:0] ints
  );
    logic [ESR_W-1:0] w;
    w = '0;
    w[POS_ERRH:POS_ERRL] = errs;
    w[POS_TXW]           = st.txw;
    w[POS_RXW]           = st.rxw;
    w[POS_IDLE]          = st.idle;
    w[POS_TXRX]          = st.txrx;
    w[POS_FLTH:POS_FLTL] = st.fault;
    w[POS_TWI]           = ints[IX_TWRN];
    w[POS_RWI]           = ints[IX_RWRN];
    w[POS_BOFF]          = ints[IX_BOFF];
    w[POS_EINT]          = ints[IX_EINT];
    w[POS_WAKE]          = ints[IX_WAKE];
    return w;
  endfunction

  function automatic logic [N_INT-1:0] clr_mask(input logic [ESR_W-1:0] wd);
    logic [N_INT-1:0] c;
    c[IX_TWRN] = wd[POS_TWI];
    c[IX_RWRN] = wd[POS_RWI];
    c[IX_BOFF] = wd[POS_BOFF];
    c[IX_EINT] = wd[POS_EINT];
    c[IX_WAKE] = wd[POS_WAKE];
    return c;
  endfunction
endpackage

// File: rtl/can_esr_sticky.sv
module can_esr_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  // A pulse on the clearing cycle survives: set is OR-ed after the clear.
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~{N{rd_clr}}) | evt;
  end
endmodule

// File: rtl/can_esr_warn.sv
module can_esr_warn #(
  parameter int CNT_W = 8,
  parameter int LVL   = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  output logic             at_lvl,
  output logic             rise
);
  localparam logic [CNT_W-1:0] LVL_V = CNT_W'(LVL);
  logic prev_q;

  assign at_lvl = (cnt >= LVL_V);
  assign rise   = en & at_lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= at_lvl;
  end
endmodule

// File: rtl/can_esr_w1c.sv
module can_esr_w1c #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flags[g] <= 1'b0;
        else if (set[g]) flags[g] <= 1'b1;
        else if (clr[g]) flags[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/can_esr.sv
module can_esr
  import can_esr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LVL = 96
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ESR_W-1:0]     bus_wdata,
  output logic [ESR_W-1:0]     bus_rdata,
  input  logic [N_ERR-1:0]     err_evt,
  input  logic [CNT_W-1:0]     tx_err_cnt,
  input  logic [CNT_W-1:0]     rx_err_cnt,
  input  logic                 st_idle,
  input  logic                 st_txrx,
  input  logic [1:0]           st_fault,
  input  logic                 boff_evt,
  input  logic                 errint_evt,
  input  logic                 wake_evt,
  input  logic                 warn_en,
  input  logic [N_INT-1:0]     irq_mask,
  output logic [N_INT-1:0]     irq
);
  logic              rd_hit;
  logic              wr_hit;
  logic [N_ERR-1:0]  err_q;
  logic [N_INT-1:0]  int_q;
  logic [N_INT-1:0]  int_set;
  logic [N_INT-1:0]  int_clr;
  logic [CNT_W-1:0]  cnt_arr [N_WARN];
  logic [N_WARN-1:0] lvl_v;
  logic [N_WARN-1:0] rise_v;
  live_stat_t        stat;

  assign rd_hit = bus_sel & bus_rd;
  assign wr_hit = bus_sel & bus_wr;

  can_esr_sticky #(.N(N_ERR)) u_err (
    .clk    (clk),
    .rst    (rst),
    .evt    (err_evt),
    .rd_clr (rd_hit),
    .flags  (err_q)
  );

  // index 1 = transmit counter, index 0 = receive counter
  assign cnt_arr[1] = tx_err_cnt;
  assign cnt_arr[0] = rx_err_cnt;

  genvar w;
  generate
    for (w = 0; w < N_WARN; w++) begin : g_warn
      can_esr_warn #(.CNT_W(CNT_W), .LVL(WARN_LVL)) u_warn (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt_arr[w]),
        .en     (warn_en),
        .at_lvl (lvl_v[w]),
        .rise   (rise_v[w])
      );
    end
  endgenerate

  always_comb begin
    int_set          = '0;
    int_set[IX_TWRN] = rise_v[1];
    int_set[IX_RWRN] = rise_v[0];
    int_set[IX_BOFF] = boff_evt;
    int_set[IX_EINT] = errint_evt;
    int_set[IX_WAKE] = wake_evt;
    int_clr          = wr_hit ? clr_mask(bus_wdata) : '0;
  end

  can_esr_w1c #(.N(N_INT)) u_int (
    .clk   (clk),
    .rst   (rst),
    .set   (int_set),
    .clr   (int_clr),
    .flags (int_q)
  );

  always_comb begin
    stat.txw   = lvl_v[1];
    stat.rxw   = lvl_v[0];
    stat.idle  = st_idle;
    stat.txrx  = st_txrx;
    stat.fault = st_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      if (rd_hit) bus_rdata <= pack_word(err_q, stat, int_q);
      irq <= int_q & irq_mask;
    end
  end
endmodule

// File: rtl/can_esr_chk.sv
module can_esr_chk
  import can_esr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LVL = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_hit,
  input logic             wr_hit,
  input logic [N_ERR-1:0] err_evt,
  input logic [N_ERR-1:0] err_q,
  input logic [N_INT-1:0] int_q,
  input logic [N_INT-1:0] int_set,
  input logic             warn_en,
  input logic [N_INT-1:0] irq_mask,
  input logic [N_INT-1:0] irq,
  input logic [ESR_W-1:0] bus_rdata,
  input logic [CNT_W-1:0] tx_err_cnt,
  input logic [CNT_W-1:0] rx_err_cnt
);
  localparam logic [CNT_W-1:0] LV = CNT_W'(WARN_LVL);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && err_evt == '0) |=> err_q == '0);

  a_r3_event_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_q & $past(err_evt)) == $past(err_evt));

  a_r4_live_warn: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (bus_rdata[POS_TXW] == $past(tx_err_cnt >= LV)) &&
               (bus_rdata[POS_RXW] == $past(rx_err_cnt >= LV)));

  a_r5_no_fall_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> (int_q & $past(int_q)) == $past(int_q));

  a_r6_tx_gate: assert property (@(posedge clk) disable iff (rst)
    (!warn_en && !int_q[IX_TWRN]) |=> !int_q[IX_TWRN]);

  a_r7_rx_gate: assert property (@(posedge clk) disable iff (rst)
    (!warn_en && !int_q[IX_RWRN]) |=> !int_q[IX_RWRN]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int_q & $past(int_set)) == $past(int_set));

  a_r10_irq_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(int_q) & $past(irq_mask)));

  a_r11_zero_bits: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[ESR_W-1:POS_TWI+1] == '0 && bus_rdata[3] == 1'b0);
endmodule

bind can_esr can_esr_chk #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_hit     (rd_hit),
  .wr_hit     (wr_hit),
  .err_evt    (err_evt),
  .err_q      (err_q),
  .int_q      (int_q),
  .int_set    (int_set),
  .warn_en    (warn_en),
  .irq_mask   (irq_mask),
  .irq        (irq),
  .bus_rdata  (bus_rdata),
  .tx_err_cnt (tx_err_cnt),
  .rx_err_cnt (rx_err_cnt)
);

// File: tb/can_esr_tb.sv
module can_esr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  err_evt = '0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        st_idle = 0, st_txrx = 0;
  logic [1:0]  st_fault = '0;
  logic        boff_evt = 0, errint_evt = 0, wake_evt = 0;
  logic        warn_en = 0;
  logic [4:0]  irq_mask = '0;
  logic [4:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  can_esr u_dut (.*);

  // {tx_cnt, rx_cnt, warn_en, exp_tx_flag, exp_rx_flag}
  localparam logic [18:0] VEC [10] = '{
    {8'd0,   8'd0,   1'b1, 1'b0, 1'b0},
    {8'd95,  8'd95,  1'b1, 1'b0, 1'b0},
    {8'd96,  8'd0,   1'b1, 1'b1, 1'b0},
    {8'd100, 8'd0,   1'b1, 1'b0, 1'b0},
    {8'd0,   8'd96,  1'b1, 1'b0, 1'b1},
    {8'd0,   8'd0,   1'b1, 1'b0, 1'b0},
    {8'd200, 8'd255, 1'b0, 1'b0, 1'b0},
    {8'd200, 8'd255, 1'b1, 1'b0, 1'b0},
    {8'd0,   8'd0,   1'b1, 1'b0, 1'b0},
    {8'd96,  8'd96,  1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic do_write(input logic [31:0] wd);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_wdata = wd;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", {27'd0, irq}, 32'd0);
    do_read(d);
    check("R1 reset word", d, 32'd0);

    // R6 R7 R4 table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      tx_err_cnt = VEC[i][18:11];
      rx_err_cnt = VEC[i][10:3];
      warn_en    = VEC[i][2];
      do_read(d);
      e = '0;
      e[17] = VEC[i][1];
      e[16] = VEC[i][0];
      e[9]  = (VEC[i][18:11] >= 8'd96);
      e[8]  = (VEC[i][10:3] >= 8'd96);
      check($sformatf("R6 R7 R4 row %0d", i), d, e);
      do_write(32'h0003_0000);
    end
    @(negedge clk);
    tx_err_cnt = 0; rx_err_cnt = 0; warn_en = 0;
    do_read(d);
    check("R5 warn flags cleared by write 1", d, 32'd0);

    // R2 sticky error flags and clear on read
    @(negedge clk); err_evt = 6'b101001;
    @(negedge clk); err_evt = 6'b000000;
    repeat (2) @(negedge clk);
    do_read(d);
    check("R2 sticky errors", d, 32'h0000_A400);
    do_read(d);
    check("R2 cleared by read", d, 32'd0);

    // R3 event in same cycle as read
    @(negedge clk); err_evt = 6'b000010; bus_sel = 1; bus_rd = 1;
    @(negedge clk); err_evt = '0; bus_sel = 0; bus_rd = 0;
    check("R3 read shows pre-clear", bus_rdata, 32'd0);
    do_read(d);
    check("R3 event kept", d, 32'h0000_0800);

    // R4 R5 R11 live status, write all ones
    @(negedge clk); st_idle = 1; st_txrx = 0; st_fault = 2'b10;
    err_evt = 6'b010000;
    @(negedge clk); err_evt = '0;
    do_write(32'hFFFF_FFFF);
    do_read(d);
    check("R4 R5 R11 status after write ones", d, 32'h0000_40A0);
    @(negedge clk); st_idle = 0; st_txrx = 1; st_fault = 2'b01;
    do_read(d);
    check("R4 live status follows inputs", d, 32'h0000_0050);
    @(negedge clk); st_txrx = 0; st_fault = 2'b00;

    // R8 R10 event flags and masked requests
    @(negedge clk); irq_mask = 5'b11111; wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    check("R10 irq one cycle later", {27'd0, irq}, 32'd0);
    @(negedge clk);
    check("R10 irq wake", {27'd0, irq}, 32'd1);
    @(negedge clk); boff_evt = 1; errint_evt = 1;
    @(negedge clk); boff_evt = 0; errint_evt = 0;
    do_read(d);
    check("R8 event flags", d, 32'h0000_0007);
    @(negedge clk); irq_mask = 5'b00101;
    repeat (2) @(negedge clk);
    check("R10 partial mask", {27'd0, irq}, 32'h0000_0005);

    // R5 write zeros then one bit
    do_write(32'h0000_0000);
    do_read(d);
    check("R5 write 0 no effect", d, 32'h0000_0007);
    do_write(32'h0000_0002);
    do_read(d);
    check("R5 write 1 clears one", d, 32'h0000_0005);

    // R12 unselected strobes
    @(negedge clk); bus_sel = 0; bus_wr = 1; bus_rd = 1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    check("R12 rdata held", bus_rdata, 32'h0000_0005);
    do_read(d);
    check("R12 flags untouched", d, 32'h0000_0005);

    // R9 set beats clear
    do_write(32'h0000_0005);
    @(negedge clk); boff_evt = 1; bus_sel = 1; bus_wr = 1; bus_wdata = 32'h0000_0004;
    @(negedge clk); boff_evt = 0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    do_read(d);
    check("R9 set wins", d, 32'h0000_0004);

    // R1 reset again clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 irq after reset", {27'd0, irq}, 32'd0);
    do_read(d);
    check("R1 word after reset", d, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule